// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block is the device side of an asynchronous multiplexed-address DRAM. A fast system clock oversamples the four active-low strobes (row strobe, column strobe, write enable, output enable) and the shared address bus. From the order in which the strobes move, the block works out what kind of memory cycle the controller is running. It then issues single-cycle read and write commands to a small on-chip storage model and decides when the data bus should be driven.

The row address is captured when the row strobe falls and the column strobe is still high. The column address is captured when the column strobe falls. A row strobe that falls while the column strobe is already low starts a counter-driven refresh, which uses a 10-bit internal row counter and then advances it. Read data follows extended-data-out rules: it stays on the bus after the column strobe rises and is only replaced or dropped at the next column fall, or when the strobes or enables take the bus away. The block suits a testbench, where it can stand in for a memory part or check one.

Top module: `dram_strobe_decoder`

## Requirements
- R1: Right after reset, `cyc_type` is 0 (idle), `dout_en`, `arr_rd`, `arr_wr` and `ref_stb` are all 0, and the refresh row counter is 0.
- R2: A read is issued at the later of the column-strobe fall and the output-enable fall while write enable is high. `arr_rd` pulses for one cycle with `arr_row` set to the row captured at the row-strobe fall and `arr_col` set to the column captured at the column-strobe fall. `cyc_type` becomes 1. The stored byte appears on `dout` with `dout_en` high one cycle after the pulse.
- R3: A column-strobe fall with write enable already low is an early write. `arr_wr` pulses with the row, the column and `din`, and `cyc_type` becomes 2. `dout_en` stays low for the whole cycle.
- R4: Write enable falling while the column strobe is low is a late write or read-modify-write. `arr_wr` pulses with `din`, `cyc_type` becomes 3, any data still driven is released, and a later read of that location returns the new byte.
- R5: With output enable high at the column fall, no read is issued. The output-enable fall then issues it. Output enable going high releases the bus, and a second output-enable fall within the same column cycle drives the data again.
- R6: While the row strobe is low, read data stays driven across the column-strobe rise. It is released at the next column-strobe fall, and the new column's data then follows.
- R7: Whenever the row strobe and the column strobe are both high, `dout_en` is 0.
- R8: A row-strobe cycle with no column-strobe fall produces a `ref_stb` pulse with `ref_row` set to the captured row when the row strobe rises. `cyc_type` becomes 4 and the bus is not driven.
- R9: A row-strobe fall while the column strobe is low produces a `ref_stb` pulse with `ref_row` set to the counter value, ignoring `addr`. The counter then advances by one and `cyc_type` becomes 5. When both strobes fall in the same sample, the cycle is also treated this way.
- R10: If read data is being driven and the row strobe falls again while the column strobe stayed low, the cycle is a hidden refresh. The refresh uses the counter row, `cyc_type` becomes 6, and the read data stays on the bus.
- R11: Every command, refresh pulse, `cyc_type` update and bus release registers 3 clocks after the strobe change that causes it. Read data and its enable register 4 clocks after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | DATA_W | Write data from the bus |
| cyc_type | output | 3 | Class of the latest decoded cycle |
| arr_rd | output | 1 | One-cycle read command to the storage |
| arr_wr | output | 1 | One-cycle write command to the storage |
| arr_row | output | ADDR_W | Row of the current command |
| arr_col | output | ADDR_W | Column of the current command |
| arr_wdata | output | DATA_W | Data of the current write command |
| ref_stb | output | 1 | One-cycle refresh pulse |
| ref_row | output | ADDR_W | Row refreshed by that pulse |
| dout | output | DATA_W | Read data for the bus |
| dout_en | output | 1 | Bus drive enable |

## Verification
Two synchronizer flops and one edge register sit between any strobe and its decision. The bench therefore drives each stimulus on a falling clock edge and samples command pulses, refresh pulses, the cycle code and bus releases exactly three falling edges later. It samples read data and its enable one falling edge after that. Because the one-cycle pulses are sampled in the only cycle they are valid, an extra or a missing pipeline stage shows up as a mismatch. A separate monitor compares `dout` against the byte the bench model expects on every clock in which `dout_en` is high, so EDO hold and hidden refresh are checked across whole sequences as well as at single sample points.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE  = 3'd0,
    CYC_READ  = 3'd1,
    CYC_EWR   = 3'd2,
    CYC_LWR   = 3'd3,
    CYC_RONLY = 3'd4,
    CYC_CBR   = 3'd5,
    CYC_HID   = 3'd6
  } cyc_e;

  localparam int STB_N   = 4;
  localparam int IDX_RAS = 0;
  localparam int IDX_CAS = 1;
  localparam int IDX_WE  = 2;
  localparam int IDX_OE  = 3;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] prv
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic m1, m2, m3;
    always_ff @(posedge clk) begin
      if (rst) begin
        m1 <= 1'b1;
        m2 <= 1'b1;
        m3 <= 1'b1;
      end else begin
        m1 <= raw[i];
        m2 <= m1;
        m3 <= m2;
      end
    end
    assign lvl[i] = m2;
    assign prv[i] = m3;
  end
endmodule

// File: rtl/bus_align.sv
module bus_align #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg;
  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
      q   <= '0;
    end else begin
      stg <= d;
      q   <= stg;
    end
  end
endmodule

// File: rtl/page_mem.sv
module page_mem #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/cycle_ctrl.sv
module cycle_ctrl
  import dsd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STB_N-1:0]  lvl,
  input  logic [STB_N-1:0]  prv,
  input  logic [ADDR_W-1:0] a_s,
  input  logic [DATA_W-1:0] d_s,
  output cyc_e              cyc_q,
  output logic              arr_rd,
  output logic              arr_wr,
  output logic [ADDR_W-1:0] arr_row,
  output logic [ADDR_W-1:0] arr_col,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              ref_stb,
  output logic [ADDR_W-1:0] ref_row,
  output logic              dout_en
);
  logic ras_lo, cas_lo, we_lo, oe_lo;
  logic ras_fall, ras_rise, cas_fall, we_fall, oe_fall;
  assign ras_lo   = ~lvl[IDX_RAS];
  assign cas_lo   = ~lvl[IDX_CAS];
  assign we_lo    = ~lvl[IDX_WE];
  assign oe_lo    = ~lvl[IDX_OE];
  assign ras_fall = prv[IDX_RAS] & ~lvl[IDX_RAS];
  assign ras_rise = ~prv[IDX_RAS] & lvl[IDX_RAS];
  assign cas_fall = prv[IDX_CAS] & ~lvl[IDX_CAS];
  assign we_fall  = prv[IDX_WE] & ~lvl[IDX_WE];
  assign oe_fall  = prv[IDX_OE] & ~lvl[IDX_OE];

  logic              ras_act, cas_hit, wr_done;
  logic [ADDR_W-1:0] row_q, col_q, rcnt;
  logic [ADDR_W-1:0] col_now;
  logic              wr_blk, trig_rd, trig_wr, rel;

  assign col_now = cas_fall ? a_s : col_q;
  assign wr_blk  = wr_done & ~cas_fall;
  assign trig_rd = ras_act & cas_lo & oe_lo & ~we_lo & (cas_fall | oe_fall) & ~wr_blk;
  assign trig_wr = ras_act & cas_lo & we_lo & (cas_fall | we_fall);
  assign rel     = (~ras_lo & ~cas_lo) | ~oe_lo | we_lo | cas_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_act   <= 1'b0;
      cas_hit   <= 1'b0;
      wr_done   <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      rcnt      <= '0;
      cyc_q     <= CYC_IDLE;
      arr_rd    <= 1'b0;
      arr_wr    <= 1'b0;
      arr_row   <= '0;
      arr_col   <= '0;
      arr_wdata <= '0;
      ref_stb   <= 1'b0;
      ref_row   <= '0;
      dout_en   <= 1'b0;
    end else begin
      arr_rd  <= trig_rd;
      arr_wr  <= trig_wr;
      ref_stb <= 1'b0;
      if (trig_rd || trig_wr) begin
        arr_row <= row_q;
        arr_col <= col_now;
      end
      if (trig_wr) arr_wdata <= d_s;

      if (ras_act && cas_fall) begin
        col_q   <= a_s;
        cas_hit <= 1'b1;
        wr_done <= 1'b0;
      end
      if (trig_wr) begin
        wr_done <= 1'b1;
        cyc_q   <= cas_fall ? CYC_EWR : CYC_LWR;
      end else if (trig_rd) begin
        cyc_q <= CYC_READ;
      end

      if (ras_fall) begin
        if (cas_lo) begin
          ref_stb <= 1'b1;
          ref_row <= rcnt;
          rcnt    <= rcnt + 1'b1;
          cyc_q   <= (dout_en && !cas_fall) ? CYC_HID : CYC_CBR;
        end else begin
          ras_act <= 1'b1;
          row_q   <= a_s;
          cas_hit <= 1'b0;
          wr_done <= 1'b0;
          cyc_q   <= CYC_IDLE;
        end
      end
      if (ras_rise) begin
        ras_act <= 1'b0;
        if (ras_act && !cas_hit) begin
          ref_stb <= 1'b1;
          ref_row <= row_q;
          cyc_q   <= CYC_RONLY;
        end
      end

      if (rel) dout_en <= 1'b0;
      else if (arr_rd) dout_en <= 1'b1;
    end
  end

  // R3
  early_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (arr_wr && cyc_q == CYC_EWR) |-> !dout_en);
  // R2
  drive_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_en) |-> $past(arr_rd));
  // R7
  both_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!ras_lo && !cas_lo) |=> !dout_en);
  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_stb && (cyc_q == CYC_CBR || cyc_q == CYC_HID)) |-> (rcnt == ref_row + 1'b1));
  // R8
  ronly_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_stb && cyc_q == CYC_RONLY) |-> !dout_en);
endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
  import dsd_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 8,
  parameter int MEM_ROW_BITS = 4,
  parameter int MEM_COL_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [2:0]        cyc_type,
  output logic              arr_rd,
  output logic              arr_wr,
  output logic [ADDR_W-1:0] arr_row,
  output logic [ADDR_W-1:0] arr_col,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              ref_stb,
  output logic [ADDR_W-1:0] ref_row,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int IDX_W = MEM_ROW_BITS + MEM_COL_BITS;

  logic [STB_N-1:0]  raw, lvl, prv;
  logic [ADDR_W-1:0] a_s;
  logic [DATA_W-1:0] d_s;
  cyc_e              cyc_q;
  logic [IDX_W-1:0]  idx;

  assign raw[IDX_RAS] = ras_n;
  assign raw[IDX_CAS] = cas_n;
  assign raw[IDX_WE]  = we_n;
  assign raw[IDX_OE]  = oe_n;

  strobe_sync #(.N(STB_N)) u_sync (
    .clk(clk), .rst(rst), .raw(raw), .lvl(lvl), .prv(prv)
  );

  bus_align #(.W(ADDR_W)) u_addr_al (.clk(clk), .rst(rst), .d(addr), .q(a_s));
  bus_align #(.W(DATA_W)) u_data_al (.clk(clk), .rst(rst), .d(din),  .q(d_s));

  cycle_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .lvl(lvl), .prv(prv), .a_s(a_s), .d_s(d_s),
    .cyc_q(cyc_q), .arr_rd(arr_rd), .arr_wr(arr_wr), .arr_row(arr_row),
    .arr_col(arr_col), .arr_wdata(arr_wdata), .ref_stb(ref_stb),
    .ref_row(ref_row), .dout_en(dout_en)
  );

  assign cyc_type = cyc_q;
  assign idx      = {arr_row[MEM_ROW_BITS-1:0], arr_col[MEM_COL_BITS-1:0]};

  page_mem #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .we(arr_wr), .waddr(idx), .wdata(arr_wdata),
    .re(arr_rd), .raddr(idx), .rdata(dout)
  );
endmodule

// File: tb/dram_strobe_decoder_tb.sv
module dram_strobe_decoder_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [9:0] addr = '0;
  logic [7:0] din = '0;
  logic [2:0] cyc_type;
  logic       arr_rd, arr_wr, ref_stb, dout_en;
  logic [9:0] arr_row, arr_col, ref_row;
  logic [7:0] arr_wdata, dout;

  int n_chk = 0, n_bad = 0;
  logic [7:0] bmem [int];
  logic [7:0] exp_rd = '0;
  int cur_row = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dram_strobe_decoder u_dut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .cyc_type(cyc_type), .arr_rd(arr_rd), .arr_wr(arr_wr),
    .arr_row(arr_row), .arr_col(arr_col), .arr_wdata(arr_wdata), .ref_stb(ref_stb),
    .ref_row(ref_row), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // every-clock comparison of driven data against the model (R2, R6, R10)
  always @(posedge clk) begin
    #2;
    if (!rst && !done && dout_en) chk("R6", "driven byte", dout, exp_rd);
  end

  task automatic early_write(input int r, input int c, input int d);
    addr = 10'(r); ras_n = 0; step(4);
    addr = 10'(c); we_n = 0; din = 8'(d); step(4);
    cas_n = 0; step(3);
    chk("R3", "arr_wr", arr_wr, 1);
    chk("R3", "row", arr_row, r);
    chk("R3", "col", arr_col, c);
    chk("R3", "wdata", arr_wdata, d);
    chk("R11", "cyc early", cyc_type, 2);
    step(1);
    chk("R3", "no drive", dout_en, 0);
    cas_n = 1; we_n = 1; ras_n = 1; step(4);
    bmem[r*1024+c] = 8'(d);
  endtask

  task automatic open_read(input int r, input int c);
    cur_row = r;
    addr = 10'(r); ras_n = 0; step(4);
    addr = 10'(c); cas_n = 0; step(3);
    chk("R2", "arr_rd", arr_rd, 1);
    chk("R2", "row", arr_row, r);
    chk("R2", "col", arr_col, c);
    chk("R2", "cyc read", cyc_type, 1);
    exp_rd = bmem[r*1024+c];
    step(1);
    chk("R11", "dout_en", dout_en, 1);
    chk("R2", "dout", dout, exp_rd);
  endtask

  task automatic page_read(input int c);
    cas_n = 1; step(4);
    chk("R6", "held after rise", dout_en, 1);
    addr = 10'(c); cas_n = 0; step(3);
    chk("R6", "release at fall", dout_en, 0);
    chk("R6", "page col", arr_col, c);
    exp_rd = bmem[cur_row*1024+c];
    step(1);
    chk("R6", "new data en", dout_en, 1);
  endtask

  task automatic close_cycle;
    cas_n = 1; ras_n = 1; step(3);
    chk("R7", "released", dout_en, 0);
    step(1);
  endtask

  initial begin
    step(5);
    rst = 0;
    step(1);
    // R1
    chk("R1", "cyc", cyc_type, 0);
    chk("R1", "dout_en", dout_en, 0);
    chk("R1", "arr_rd", arr_rd, 0);
    chk("R1", "arr_wr", arr_wr, 0);
    chk("R1", "ref_stb", ref_stb, 0);

    early_write(3, 5, 8'hA5);
    early_write(3, 6, 8'h3C);

    open_read(3, 5);
    page_read(6);
    oe_n = 1; step(3);
    chk("R5", "oe release", dout_en, 0);
    step(1);
    oe_n = 0; step(4);
    chk("R5", "oe redrive", dout_en, 1);
    close_cycle();

    // R5: output-enable fall issues the read
    oe_n = 1; step(2);
    addr = 10'd3; ras_n = 0; step(4);
    addr = 10'd5; cas_n = 0; step(3);
    chk("R5", "no read with oe high", arr_rd, 0);
    step(1);
    oe_n = 0; exp_rd = bmem[3*1024+5]; step(3);
    chk("R5", "read on oe fall", arr_rd, 1);
    step(1);
    chk("R5", "drive", dout_en, 1);
    // R4 read-modify-write
    cur_row = 3;
    page_read(6);
    oe_n = 1; step(4);
    din = 8'h77; we_n = 0; step(3);
    chk("R4", "arr_wr", arr_wr, 1);
    chk("R4", "cyc late", cyc_type, 3);
    chk("R4", "col", arr_col, 6);
    chk("R4", "wdata", arr_wdata, 8'h77);
    step(1);
    chk("R4", "bus off", dout_en, 0);
    oe_n = 0; we_n = 1; cas_n = 1; ras_n = 1; step(4);
    bmem[3*1024+6] = 8'h77;
    open_read(3, 6);
    close_cycle();

    // R8 row-only refresh
    addr = 10'd9; ras_n = 0; step(4);
    ras_n = 1; step(3);
    chk("R8", "ref_stb", ref_stb, 1);
    chk("R8", "ref_row", ref_row, 9);
    chk("R8", "cyc", cyc_type, 4);
    chk("R8", "no drive", dout_en, 0);
    step(1);

    // R9 counter refresh
    cas_n = 0; step(4);
    addr = 10'h155; ras_n = 0; step(3);
    chk("R9", "ref_stb", ref_stb, 1);
    chk("R9", "counter row", ref_row, 0);
    chk("R9", "cyc", cyc_type, 5);
    step(1);
    ras_n = 1; step(4);
    ras_n = 0; step(3);
    chk("R9", "counter advanced", ref_row, 1);
    step(1);
    ras_n = 1; cas_n = 1; step(4);
    ras_n = 0; cas_n = 0; step(3);
    chk("R9", "same-sample cyc", cyc_type, 5);
    chk("R9", "same-sample row", ref_row, 2);
    chk("R9", "no drive", dout_en, 0);
    step(1);
    ras_n = 1; cas_n = 1; step(4);

    // R10 hidden refresh
    open_read(3, 5);
    ras_n = 1; step(4);
    chk("R10", "held after ras rise", dout_en, 1);
    ras_n = 0; step(3);
    chk("R10", "ref_stb", ref_stb, 1);
    chk("R10", "cyc", cyc_type, 6);
    chk("R10", "counter row", ref_row, 3);
    chk("R10", "still driven", dout_en, 1);
    chk("R10", "data", dout, 8'hA5);
    step(1);
    ras_n = 1; step(4);
    cas_n = 1; step(3);
    chk("R7", "released", dout_en, 0);
    step(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog: got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule